// File: doc/BRIEF.md
# Input Pin Change Monitor

This block keeps watch over four general-purpose input pins and folds what it sees into one byte that a processor can read. The low nibble holds a snapshot of the pin levels taken at the most recent level change on any pin. The high nibble holds one sticky flag per pin, marking that the pin has toggled since the byte was last read. Whenever any of those flags is raised, an interrupt request output goes high.

Software reads the byte by pulsing a read strobe. The byte is presented combinationally on the read data bus, so the value seen during the strobe is the full register. At the clock edge that ends the strobe, the flag nibble and the interrupt request are cleared, while the level snapshot is kept. Each pin is brought into the clock domain through a chain of synchronising flops before any comparison is made.

Top module: `pin_delta_watch`

## Requirements
- R1: Each pin passes through two synchronising flops and one compare stage, so a new pin level first shows in `rd_data` after the third rising clock edge, counting the edge that first samples it.
- R2: When pin n changes level, `rd_data[3:0]` is loaded with the synchronised levels of all four pins (bit n for pin n) and `rd_data[4+n]` is set.
- R3: A flag in `rd_data[7:4]` that is set stays set, with no read, until a read clears it; no flag is set while the pins hold steady.
- R4: While `rd_stb` is high, `rd_data` shows the whole byte; after the clock edge that samples `rd_stb`, `rd_data[7:4]` is zero, `rd_data[3:0]` is unchanged and `chg_irq` is low.
- R5: A synchronous reset clears the stored pin levels, the snapshot, the flags and `chg_irq`; a pin held high through reset is therefore reported as a change once reset is released.
- R6: `chg_irq` goes high on the same edge that sets any flag and stays high exactly while any flag in `rd_data[7:4]` is set.
- R7: A change that is registered on the same edge as a read keeps its new flag and `chg_irq`; only the flags set before that edge are cleared.
- R8: Several pins changing together set all of their flags in a single update.
- R9: A pin that changes back to its earlier level updates the snapshot while its flag, already set, stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 4 | Raw asynchronous input pins, bit n is pin n |
| rd_stb | input | 1 | Read strobe; clears the flags at the clock edge that samples it |
| rd_data | output | 8 | Change byte: flags in bits 7:4, level snapshot in bits 3:0 |
| chg_irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
A pin level driven before an edge reaches `rd_data` three rising edges later, so every pin-driven check is taken at the falling edge after the third rising edge, and the latency itself is pinned by a check one edge earlier that must still see the old byte. The effect of a read appears one edge after the strobe is sampled, and the byte returned by the read is checked while the strobe is still high, before that edge. The read-collision case is timed by raising the strobe for exactly the edge on which the synchronised change is registered, and the reset case counts three edges from the release before expecting the held-high pins to show.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    // Number of watched pins and derived register geometry.
    localparam int unsigned PDW_PINS  = 4;
    localparam int unsigned PDW_REG_W = 2 * PDW_PINS;

    typedef logic [PDW_PINS-1:0]  pin_vec_t;
    typedef logic [PDW_REG_W-1:0] reg_byte_t;

    // Register layout: flags in the upper half, level snapshot in the lower.
    typedef struct packed {
        pin_vec_t flag;
        pin_vec_t level;
    } chg_reg_t;

    localparam chg_reg_t CHG_REG_RESET = '{flag: '0, level: '0};

    // Flag update: a read wipes the old flags, fresh changes always land.
    function automatic pin_vec_t next_flags(
        input pin_vec_t cur_flags,
        input pin_vec_t changed,
        input logic     read_now
    );
        pin_vec_t kept;
        kept = read_now ? '0 : cur_flags;
        return kept | changed;
    endfunction

    // Interrupt update follows the same clear-then-merge rule.
    function automatic logic next_irq(
        input logic     cur_irq,
        input pin_vec_t changed,
        input logic     read_now
    );
        logic kept;
        kept = read_now ? 1'b0 : cur_irq;
        return kept | (|changed);
    endfunction

    function automatic reg_byte_t pack_reg(input chg_reg_t r);
        return {r.flag, r.level};
    endfunction

endpackage

// File: rtl/pdw_sync.sv
module pdw_sync
    import pdw_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t raw_i,
    output pin_vec_t sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    // One independent flop chain per pin.
    for (genvar p = 0; p < PDW_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q[0] <= raw_i[p];
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], raw_i[p]};
                end
            end
        end

        assign sync_o[p] = chain_q[LAST];
    end

endmodule

// File: rtl/pdw_edge.sv
module pdw_edge
    import pdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t sync_i,
    output pin_vec_t changed_o
);

    // Last level seen on each synchronised pin; zero after reset so that a
    // pin held high through reset reports a change.
    pin_vec_t seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else begin
            seen_q <= sync_i;
        end
    end

    for (genvar p = 0; p < PDW_PINS; p++) begin : g_cmp
        assign changed_o[p] = sync_i[p] ^ seen_q[p];
    end

endmodule

// File: rtl/pdw_reg.sv
module pdw_reg
    import pdw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t sync_i,
    input  pin_vec_t changed_i,
    input  logic     rd_stb,
    output chg_reg_t reg_o,
    output logic     irq_o
);

    chg_reg_t reg_q, reg_d;
    logic     irq_q, irq_d;
    logic     any_change;

    assign any_change = |changed_i;

    always_comb begin
        reg_d      = reg_q;
        reg_d.flag = next_flags(reg_q.flag, changed_i, rd_stb);
        if (any_change) begin
            reg_d.level = sync_i;
        end
        irq_d = next_irq(irq_q, changed_i, rd_stb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= CHG_REG_RESET;
            irq_q <= 1'b0;
        end else begin
            reg_q <= reg_d;
            irq_q <= irq_d;
        end
    end

    assign reg_o = reg_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/pin_delta_watch.sv
module pin_delta_watch
    import pdw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PDW_PINS-1:0]  pins_i,
    input  logic                 rd_stb,
    output logic [PDW_REG_W-1:0] rd_data,
    output logic                 chg_irq
);

    pin_vec_t sync_w;
    pin_vec_t change_w;
    chg_reg_t reg_w;

    pdw_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (pins_i),
        .sync_o(sync_w)
    );

    pdw_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_w),
        .changed_o(change_w)
    );

    pdw_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_w),
        .changed_i(change_w),
        .rd_stb   (rd_stb),
        .reg_o    (reg_w),
        .irq_o    (chg_irq)
    );

    assign rd_data = pack_reg(reg_w);

endmodule

// File: rtl/pdw_checker.sv
module pdw_checker
    import pdw_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_stb,
    input logic [PDW_REG_W-1:0] rd_data,
    input logic                 chg_irq,
    input logic [PDW_PINS-1:0]  change_vec,
    input logic [PDW_PINS-1:0]  sync_lvl
);

    // R2: a detected change loads the snapshot and raises the pin's flag.
    p_change_load_r2: assert property (@(posedge clk) disable iff (rst)
        (change_vec != '0) |=>
            (rd_data[PDW_PINS-1:0] == $past(sync_lvl)) &&
            ((rd_data[PDW_REG_W-1:PDW_PINS] & $past(change_vec)) == $past(change_vec)));

    // R3: without a read no flag ever drops.
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=>
            ((rd_data[PDW_REG_W-1:PDW_PINS] & $past(rd_data[PDW_REG_W-1:PDW_PINS]))
             == $past(rd_data[PDW_REG_W-1:PDW_PINS])));

    // R3: steady pins leave the whole byte alone unless a read happens.
    p_steady_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (change_vec == '0 && !rd_stb) |=> $stable(rd_data));

    // R4: a read with no collision empties the flags and keeps the levels.
    p_read_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && change_vec == '0) |=>
            (rd_data[PDW_REG_W-1:PDW_PINS] == '0) && !chg_irq &&
            (rd_data[PDW_PINS-1:0] == $past(rd_data[PDW_PINS-1:0])));

    // R5: reset leaves an all-zero byte and a quiet interrupt.
    p_reset_clear_r5: assert property (@(posedge clk)
        rst |=> (rd_data == '0) && !chg_irq);

    // R6: interrupt rises with the flag and matches flag occupancy.
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (change_vec != '0) |=> chg_irq);

    p_irq_match_r6: assert property (@(posedge clk) disable iff (rst)
        chg_irq == (rd_data[PDW_REG_W-1:PDW_PINS] != '0));

    // R7: a change colliding with a read survives, older flags do not.
    p_read_race_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && change_vec != '0) |=>
            (rd_data[PDW_REG_W-1:PDW_PINS] == $past(change_vec)) && chg_irq);

endmodule

bind pin_delta_watch pdw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .chg_irq   (chg_irq),
    .change_vec(change_w),
    .sync_lvl  (sync_w)
);

// File: tb/sim_pin_delta_watch.sv
module sim_pin_delta_watch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins = 4'h0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       chg_irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    pin_delta_watch u0 (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins),
        .rd_stb (rd_stb),
        .rd_data(rd_data),
        .chg_irq(chg_irq)
    );

    // Vector fields: {pins[3:0], do_read, expected byte[7:0], expected irq}
    localparam int NV = 7;
    localparam logic [13:0] VEC [NV] = '{
        {4'b0001, 1'b0, 8'h11, 1'b1},   // pin0 rises
        {4'b0011, 1'b1, 8'h33, 1'b1},   // pin1 rises, pin0 flag sticky
        {4'b0011, 1'b0, 8'h03, 1'b0},   // no change after read
        {4'b1100, 1'b1, 8'hFC, 1'b1},   // all four toggle together
        {4'b1000, 1'b1, 8'h48, 1'b1},   // pin2 falls
        {4'b0000, 1'b0, 8'h80, 1'b1},   // pin3 falls
        {4'b1000, 1'b1, 8'h88, 1'b1}    // pin3 back, flag stays
    };
    localparam string VTAG [NV] = '{"R2", "R3", "R3", "R8", "R2", "R2", "R9"};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act_d, input logic act_i,
                         input logic [7:0] exp_d, input logic exp_i);
        total++;
        if (act_d !== exp_d || act_i !== exp_i) begin
            bad++;
            $display("FAIL %s: actual data=%02h irq=%0b expected data=%02h irq=%0b",
                     tag, act_d, act_i, exp_d, exp_i);
        end
    endtask

    task automatic do_read(input string tag, input logic [7:0] pre_d,
                           input logic pre_i);
        rd_stb = 1'b1;
        #1;
        check({tag, " read returns byte R4"}, rd_data, chg_irq, pre_d, pre_i);
        step(1);
        rd_stb = 1'b0;
        #1;
        check({tag, " after read R4"}, rd_data, chg_irq, {4'h0, pre_d[3:0]}, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all R): actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        step(4);
        check("R5 reset state", rd_data, chg_irq, 8'h00, 1'b0);
        rst = 1'b0;
        step(5);
        check("R3 idle after reset", rd_data, chg_irq, 8'h00, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            pins = VEC[i][13:10];
            step(3);
            check(VTAG[i], rd_data, chg_irq, VEC[i][8:1], VEC[i][0]);
            if (VEC[i][9]) begin
                do_read(VTAG[i], VEC[i][8:1], VEC[i][0]);
            end
        end

        // R1: latency; state now 0x08
        pins = 4'b1001;
        step(2);
        check("R1 not yet visible", rd_data, chg_irq, 8'h08, 1'b0);
        step(1);
        check("R1 visible on third edge R6", rd_data, chg_irq, 8'h19, 1'b1);

        // R7: read on the same edge the pin1 change is registered
        pins = 4'b1011;
        step(2);
        rd_stb = 1'b1;
        #1;
        check("R7 byte during read", rd_data, chg_irq, 8'h19, 1'b1);
        step(1);
        rd_stb = 1'b0;
        #1;
        check("R7 new flag survives read", rd_data, chg_irq, 8'h2B, 1'b1);
        do_read("R7", 8'h2B, 1'b1);

        // R5: reset with pins held high
        pins = 4'b0101;
        rst  = 1'b1;
        step(3);
        check("R5 reset clears state", rd_data, chg_irq, 8'h00, 1'b0);
        rst = 1'b0;
        step(2);
        check("R5 held pins not yet seen", rd_data, chg_irq, 8'h00, 1'b0);
        step(1);
        check("R5 held-high pins reported", rd_data, chg_irq, 8'h55, 1'b1);
        do_read("R5", 8'h55, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule